// File: doc/BRIEF.md
# Step-Adaptive Decimation Output Filter

This block takes the sample stream coming out of a sinc3 decimator and delivers one filtered word for every input sample. In its normal path the word is a 22-tap FIR over the most recent decimator samples. A bypass control makes the decimator sample itself the result.

A step-response mode can be switched on. When a new sample jumps away from the last result by more than a threshold, the FIR output is set aside. The block then emits a moving average whose window doubles on each output: 2, 4, 8, then 16 samples. It stays at 16 until the FIR delay line holds only post-step data. At that point the FIR result is used again. A settled flag leaves the block with every result and shows whether the FIR is in charge.

Each sample arrives with a one-cycle valid pulse. The matching result appears with a one-cycle valid pulse exactly one clock later.

Top module: `stepadapt_filter`

## Requirements
- R1: While reset is high and on the first cycle after it, res_valid is 0, res_data is 0 and res_settled is 1. The delay line starts all-zero, so samples before reset count as 0.
- R2: res_valid pulses high exactly one cycle after each smp_valid pulse, and it is low in every other cycle. res_data and res_settled change only together with that pulse.
- R3: With fir_bypass at 1, the result equals the input sample, res_settled is 1 and no step mode is entered or kept.
- R4: With fir_bypass at 0 and no step mode active, the result is the sum over k=0..21 of c_k·x[n−k], shifted arithmetically right by 7. The weights are c_k = k+1 for k<11 and 22−k otherwise, and x[n] is the current sample. The result is clamped to the signed 16-bit range.
- R5: A step is declared only when step_mode_en is 1, fir_bypass is 0, no step mode is already active, and |x[n] − previous res_data| > 1000. A difference of exactly 1000 is not a step. On a step, res_settled goes low with that sample's result.
- R6: The result of the step sample is (x[n] + x[n−1]) arithmetically shifted right by 1, which rounds toward minus infinity.
- R7: The next post-step results average the latest 4, then 8, then 16 samples, each by arithmetic right shift. The window stays at 16 for every later result of the same step.
- R8: Counting the step sample as the first, post-step samples 1 to 21 give averaged results with res_settled at 0. The 22nd gives the FIR result of R4 with res_settled back at 1.
- R9: If step_mode_en is cleared or fir_bypass is set while a step mode is active, the step mode ends. The next result takes the normal path and res_settled is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One-cycle pulse marking a new decimator sample |
| smp_data | input | 16 | Signed decimator sample |
| fir_bypass | input | 1 | 1 passes samples straight to the result |
| step_mode_en | input | 1 | 1 enables step detection and the averaging mode |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 16 | Signed filter result |
| res_settled | output | 1 | 1 when the result comes from the normal path |

## Verification
Several rules are checked on every cycle: the one-cycle output timing, the pass-through in bypass mode, that the settled flag falls only on an enabled sample, that the averaging window tracks the post-step sample count, that this count stays inside the FIR length, and that disabling the mode clears it. The arithmetic can only be shown by the bench's scenarios. These cover the FIR sums with clamping at both rails, the floor rounding of negative averages, the exact 1000 boundary of step detection, and the exact sample on which the FIR returns.

// File: rtl/saf_pkg.sv
package saf_pkg;
  // Triangular FIR weight for tap k of an n-tap filter.
  function automatic int tap_weight(input int k, input int n);
    int half;
    half = n / 2;
    if (k < half) return k + 1;
    return n - k;
  endfunction
endpackage

// File: rtl/saf_delay_line.sv
module saf_delay_line #(
  parameter int DW    = 16,
  parameter int DEPTH = 21
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        shift,
  input  logic signed [DW-1:0]        din,
  output logic [DEPTH-1:0][DW-1:0]    taps
);
  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else if (shift) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end
endmodule

// File: rtl/saf_fir.sv
module saf_fir
  import saf_pkg::*;
#(
  parameter int DW        = 16,
  parameter int NTAPS     = 22,
  parameter int COEF_SHIFT = 7
) (
  input  logic [NTAPS-1:0][DW-1:0] win,
  output logic signed [DW-1:0]     y
);
  localparam int ACCW = DW + $clog2(NTAPS) + 6;
  localparam logic signed [ACCW-1:0] HI = ACCW'((2 ** (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] LO = -ACCW'(2 ** (DW - 1));

  logic signed [ACCW-1:0] prod [NTAPS];
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] scaled;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam int WGT = tap_weight(k, NTAPS);
    logic signed [DW-1:0] s;
    assign s       = $signed(win[k]);
    assign prod[k] = ACCW'(s) * ACCW'(WGT);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) acc = acc + prod[k];
    scaled = acc >>> COEF_SHIFT;
    if (scaled > HI)      y = HI[DW-1:0];
    else if (scaled < LO) y = LO[DW-1:0];
    else                  y = scaled[DW-1:0];
  end
endmodule

// File: rtl/saf_window_avg.sv
module saf_window_avg #(
  parameter int DW    = 16,
  parameter int NTAPS = 22,
  parameter int NWIN  = 4,
  localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [NTAPS-1:0][DW-1:0] win,
  input  logic [IDXW-1:0]          sel,
  output logic signed [DW-1:0]     y
);
  localparam int SW = DW + NWIN + 1;

  logic signed [DW-1:0] avg [NWIN];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam int LEN = 2 << i;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] shifted;
    always_comb begin
      sum = '0;
      for (int j = 0; j < LEN; j++) sum = sum + SW'($signed(win[j]));
      shifted = sum >>> (i + 1);
    end
    assign avg[i] = shifted[DW-1:0];
  end

  always_comb begin
    y = avg[0];
    for (int i = 0; i < NWIN; i++) if (sel == IDXW'(i)) y = avg[i];
  end
endmodule

// File: rtl/saf_step_ctrl.sv
module saf_step_ctrl #(
  parameter int NTAPS = 22,
  parameter int NWIN  = 4,
  localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int CNTW = $clog2(NTAPS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            enable,
  input  logic            hit,
  output logic            use_avg,
  output logic [IDXW-1:0] cur_sel,
  output logic            nxt_active
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NWIN - 1);

  logic            active, act_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic [IDXW-1:0] widx, widx_n;

  always_comb begin
    use_avg = 1'b0;
    cur_sel = '0;
    act_n   = active;
    cnt_n   = cnt;
    widx_n  = widx;
    if (!enable) begin
      act_n = 1'b0;
    end else if (adv) begin
      if (!active) begin
        if (hit) begin
          use_avg = 1'b1;
          act_n   = 1'b1;
          cnt_n   = CNTW'(1);
          widx_n  = IDXW'(1);
        end
      end else if (cnt == CNTW'(NTAPS - 1)) begin
        act_n = 1'b0;
      end else begin
        use_avg = 1'b1;
        cur_sel = widx;
        cnt_n   = cnt + CNTW'(1);
        if (widx != LAST) widx_n = widx + IDXW'(1);
      end
    end
  end

  assign nxt_active = act_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      widx   <= '0;
    end else begin
      active <= act_n;
      cnt    <= cnt_n;
      widx   <= widx_n;
    end
  end

  // R7
  win_track_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (widx == ((cnt > CNTW'(LAST)) ? LAST : IDXW'(cnt))));

  // R8
  settle_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0 && cnt < CNTW'(NTAPS)));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> !active);
endmodule

// File: rtl/stepadapt_filter.sv
module stepadapt_filter #(
  parameter int DW          = 16,
  parameter int NTAPS       = 22,
  parameter int COEF_SHIFT  = 7,
  parameter int STEP_THRESH = 1000,
  parameter int NWIN        = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  input  logic                 fir_bypass,
  input  logic                 step_mode_en,
  output logic                 res_valid,
  output logic signed [DW-1:0] res_data,
  output logic                 res_settled
);
  localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int DIFW = DW + 2;

  logic [NTAPS-2:0][DW-1:0] line;
  logic [NTAPS-1:0][DW-1:0] win;
  logic signed [DW-1:0]     fir_y, avg_y;
  logic signed [DIFW-1:0]   diff, mag;
  logic                     hit, use_avg, nxt_active, mode_en;
  logic [IDXW-1:0]          cur_sel;
  logic signed [DW-1:0]     pick;

  saf_delay_line #(.DW(DW), .DEPTH(NTAPS - 1)) u_line (
    .clk(clk), .rst(rst), .shift(smp_valid), .din(smp_data), .taps(line)
  );

  assign win = {line, smp_data};

  saf_fir #(.DW(DW), .NTAPS(NTAPS), .COEF_SHIFT(COEF_SHIFT)) u_fir (
    .win(win), .y(fir_y)
  );

  saf_window_avg #(.DW(DW), .NTAPS(NTAPS), .NWIN(NWIN)) u_avg (
    .win(win), .sel(cur_sel), .y(avg_y)
  );

  assign diff    = DIFW'(smp_data) - DIFW'(res_data);
  assign mag     = diff[DIFW-1] ? -diff : diff;
  assign hit     = mag > DIFW'(STEP_THRESH);
  assign mode_en = step_mode_en && !fir_bypass;

  saf_step_ctrl #(.NTAPS(NTAPS), .NWIN(NWIN)) u_ctrl (
    .clk(clk), .rst(rst), .adv(smp_valid), .enable(mode_en), .hit(hit),
    .use_avg(use_avg), .cur_sel(cur_sel), .nxt_active(nxt_active)
  );

  always_comb begin
    if (fir_bypass)   pick = smp_data;
    else if (use_avg) pick = avg_y;
    else              pick = fir_y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_settled <= 1'b1;
    end else begin
      res_valid <= smp_valid;
      if (smp_valid) begin
        res_data    <= pick;
        res_settled <= !nxt_active;
      end
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(smp_valid));

  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(fir_bypass)) |-> (res_data == $past(smp_data) && res_settled));

  // R5
  step_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(res_settled) |-> $past(step_mode_en && !fir_bypass && smp_valid));
endmodule

// File: tb/stepadapt_filter_tb_top.sv
module stepadapt_filter_tb_top;
  localparam int DW = 16;
  localparam int NT = 22;
  localparam int SH = 7;
  localparam int TH = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [DW-1:0] smp_data = '0;
  logic fir_bypass = 1'b0;
  logic step_mode_en = 1'b0;
  logic res_valid;
  logic signed [DW-1:0] res_data;
  logic res_settled;

  always #5 clk = ~clk;

  stepadapt_filter #(.DW(DW), .NTAPS(NT), .COEF_SHIFT(SH), .STEP_THRESH(TH), .NWIN(4)) dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .fir_bypass(fir_bypass), .step_mode_en(step_mode_en),
    .res_valid(res_valid), .res_data(res_data), .res_settled(res_settled)
  );

  int n_chk = 0;
  int n_fail = 0;
  int hist [NT];
  int m_prev = 0;
  bit m_act = 0;
  int m_cnt = 0;
  int m_widx = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int weight(input int k);
    return (k < NT / 2) ? k + 1 : NT - k;
  endfunction

  // Model per requirement: returns expected result, sets tag and settled flag.
  task automatic model(input int x, input bit byp, input bit fe,
                       output int exp, output bit st, output string tag);
    int fir, w, s;
    bit en, hit, use_avg;
    for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    en  = fe && !byp;
    hit = ((x - m_prev) > TH) || ((m_prev - x) > TH);
    use_avg = 0;
    w = 0;
    tag = "R4";
    if (!en) m_act = 0;
    else if (!m_act && hit) begin
      use_avg = 1; w = 2; m_act = 1; m_cnt = 1; m_widx = 1; tag = "R6";
    end else if (m_act) begin
      if (m_cnt == NT - 1) begin m_act = 0; tag = "R8"; end
      else begin
        use_avg = 1; w = 2 << m_widx; m_cnt++; tag = "R7";
        if (m_widx < 3) m_widx++;
      end
    end
    if (byp) begin
      exp = x; tag = "R3";
    end else if (use_avg) begin
      s = 0;
      for (int j = 0; j < w; j++) s += hist[j];
      exp = s >>> $clog2(w);
    end else begin
      fir = 0;
      for (int k = 0; k < NT; k++) fir += weight(k) * hist[k];
      exp = fir >>> SH;
      if (exp > 32767) exp = 32767;
      if (exp < -32768) exp = -32768;
    end
    st = !m_act;
    m_prev = exp;
  endtask

  task automatic push(input int x, input bit byp, input bit fe, input string sreq);
    int exp;
    bit st;
    string tag;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = DW'(x);
    fir_bypass = byp;
    step_mode_en = fe;
    model(x, byp, fe, exp, st, tag);
    @(negedge clk);
    smp_valid = 1'b0;
    check("R2 valid pulse", int'(res_valid), 1);
    check(tag, int'(res_data), exp);
    check(sreq, int'(res_settled), int'(st));
    @(negedge clk);
    check("R2 idle", int'(res_valid), 0);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 valid", int'(res_valid), 0);
    check("R1 data", int'(res_data), 0);
    check("R1 settled", int'(res_settled), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after", int'(res_valid), 0);
    check("R1 settled after", int'(res_settled), 1);

    // R3: bypass with edge values, step mode requested but ignored
    push(-32768, 1, 1, "R3"); push(-1, 1, 1, "R3"); push(0, 1, 1, "R3");
    push(1, 1, 1, "R3"); push(32767, 1, 1, "R3"); push(-20000, 1, 1, "R3");

    // R4: FIR over a pseudo-random pattern, then both clamp rails
    for (int i = 0; i < 30; i++) push(((i * 1237) % 4001) - 2000, 0, 0, "R4");
    for (int i = 0; i < NT; i++) push(32767, 0, 0, "R4");
    for (int i = 0; i < NT; i++) push(-32768, 0, 0, "R4");
    for (int i = 0; i < 25; i++) push(100, 0, 0, "R4");

    // R5: exact threshold is no step, one above is a step
    push(m_prev + TH, 0, 1, "R5");
    push(m_prev + TH + 1, 0, 1, "R5");
    // R7/R8: growth and return to FIR
    for (int i = 0; i < 25; i++) push(5000, 0, 1, "R8");
    // R6: negative step with odd values exercises floor rounding
    push(-3001, 0, 1, "R5");
    for (int i = 0; i < 24; i++) push(-3001 + (i % 3), 0, 1, "R8");

    // R9: abort by clearing the mode, then by bypass
    push(4000, 0, 1, "R5");
    for (int i = 0; i < 3; i++) push(4000, 0, 1, "R7");
    push(4000, 0, 0, "R9");
    for (int i = 0; i < NT; i++) push(4000, 0, 1, "R9");
    push(-4000, 0, 1, "R5");
    push(-4000, 0, 1, "R7");
    push(-4000, 1, 1, "R9");
    push(-4000, 0, 1, "R9");

    summary();
    $finish;
  end
endmodule